// File: doc/BRIEF.md
# Memory Module Timing Byte Decoder

This block takes the timing bytes of a DDR3 module's presence-detect table. They arrive one at a time as address/data pairs on a valid/ready stream. The block turns the stored times into controller clock-cycle counts for a clock period supplied on `tck_units`. All times and the clock period are in medium-timebase units of 0.125 ns. For example, a period value of 10 means 1.25 ns and a time byte of 0x69 means 13.125 ns.

Software or an I2C reader streams the relevant bytes in and then pulses `go`. The block then runs one restoring ceiling division per timing parameter, at one quotient bit per clock. After the last division it searches the supported-CAS-latency mask for the smallest latency that covers the access time. It then pulses `done` with every count registered. Captured bytes persist, so a later `go` with only a new period re-converts the same table.

The input stream is ready only while the block is idle. From the cycle after `go` is accepted until `done`, `in_ready` is low and a valid byte is held off, not dropped.

Top module: `spd_timing_decoder`

## Requirements
- R1: A byte is taken only in a cycle with `in_valid` and `in_ready` both high. `in_ready` is high while idle and falls in the cycle after `go` is accepted. It stays low until the cycle in which `done` is high. Bytes offered meanwhile leave every result unchanged.
- R2: Single-byte times are taken from these addresses: access time 16, row-to-column 18, active-to-active 19, precharge 20, write-to-read 26 and read-to-precharge 27. The latency mask comes from address 14 (low eight bits) and address 15 (high eight bits).
- R3: Split times are assembled as follows:
  - active-to-precharge = {addr 21 bits 3:0, addr 22}
  - active-to-active/refresh = {addr 21 bits 7:4, addr 23}
  - refresh recovery = {addr 25, addr 24}
  - four-activate window = {addr 28 bits 3:0, addr 29}; bits 7:4 of address 28 are ignored.
- R4: Each count equals ceil(time / tck_units), using the `tck_units` value sampled at `go`.
- R5: A time that is an exact multiple of the period gives the plain quotient, not one more.
- R6: Mask bit i (0..15, low byte first) means latency i+4 is supported. `cl_sel` is the smallest supported latency not below the access-time count. High-byte bits take part in the search.
- R7: If no supported latency qualifies, `cl_err` is 1 and `cl_sel` is 0.
- R8: `done` is a single-cycle pulse after all ten counts and the latency are registered. The outputs hold until the next run.
- R9: Bytes written to addresses outside the ones listed in R2 and R3 change no result.
- R10: After reset: `in_ready`=1, `done`=0, `cl_err`=0, `cl_sel`=0 and all counts 0.
- R11: Captured bytes persist across runs, so a new run with only a new period re-converts the stored table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte can be taken (idle) |
| in_addr | input | 8 | Table byte address |
| in_data | input | 8 | Table byte value |
| go | input | 1 | Start conversion (taken while idle) |
| tck_units | input | 8 | Clock period in 0.125 ns units |
| done | output | 1 | One-cycle completion pulse |
| cl_sel | output | 5 | Chosen CAS latency |
| cl_err | output | 1 | No supported latency qualifies |
| cyc_aa | output | 16 | Access time in cycles |
| cyc_rcd | output | 16 | Row-to-column delay in cycles |
| cyc_rp | output | 16 | Precharge time in cycles |
| cyc_ras | output | 16 | Active-to-precharge in cycles |
| cyc_rc | output | 16 | Active-to-active/refresh in cycles |
| cyc_rfc | output | 16 | Refresh recovery in cycles |
| cyc_faw | output | 16 | Four-activate window in cycles |
| cyc_rrd | output | 16 | Active-to-active other bank in cycles |
| cyc_wtr | output | 16 | Write-to-read in cycles |
| cyc_rtp | output | 16 | Read-to-precharge in cycles |

## Verification
A realistic table at 1.25, 1.5 and 1.875 ns periods checks rounding: 1.875 ns divides the access time exactly, which separates a true ceiling from a plain add-one. Nibble-rich split bytes with unused upper bits set show whether each half lands in the right field. Masks are varied to force three outcomes: a pick from the high mask byte, a pick that skips unsupported lower latencies, and the no-match error. Writes to unmapped addresses and writes offered while busy must leave the results unchanged.

// File: rtl/spd_pkg.sv
package spd_pkg;
  localparam int BYTE_W  = 8;
  localparam int TIME_W  = 16;
  localparam int NF      = 10;
  localparam int MASK_W  = 16;
  localparam int CL_BASE = 4;

  typedef enum logic [3:0] {
    F_AA, F_RCD, F_RP, F_RAS, F_RC, F_RFC, F_FAW, F_RRD, F_WTR, F_RTP
  } field_e;
endpackage

// File: rtl/spd_byte_capture.sv
module spd_byte_capture
  import spd_pkg::*;
#(
  parameter int BW = BYTE_W,
  parameter int TW = TIME_W,
  parameter int MW = MASK_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [BW-1:0] wr_addr,
  input  logic [BW-1:0] wr_data,
  output logic [TW-1:0] times [NF],
  output logic [MW-1:0] cl_mask
);
  localparam int HW = BW / 2;

  logic [BW-1:0] m_lo, m_hi, t_aa, t_rcd, t_rrd, t_rp, nib, ras_lo, rc_lo;
  logic [BW-1:0] rfc_lo, rfc_hi, t_wtr, t_rtp, faw_lo;
  logic [HW-1:0] faw_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_lo, m_hi, t_aa, t_rcd, t_rrd, t_rp, nib, ras_lo, rc_lo} <= '0;
      {rfc_lo, rfc_hi, t_wtr, t_rtp, faw_lo, faw_hi} <= '0;
    end else if (wr_en) begin
      case (int'(wr_addr))
        14: m_lo   <= wr_data;
        15: m_hi   <= wr_data;
        16: t_aa   <= wr_data;
        18: t_rcd  <= wr_data;
        19: t_rrd  <= wr_data;
        20: t_rp   <= wr_data;
        21: nib    <= wr_data;
        22: ras_lo <= wr_data;
        23: rc_lo  <= wr_data;
        24: rfc_lo <= wr_data;
        25: rfc_hi <= wr_data;
        26: t_wtr  <= wr_data;
        27: t_rtp  <= wr_data;
        28: faw_hi <= wr_data[HW-1:0];
        29: faw_lo <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    times[int'(F_AA)]  = TW'(t_aa);
    times[int'(F_RCD)] = TW'(t_rcd);
    times[int'(F_RP)]  = TW'(t_rp);
    times[int'(F_RAS)] = TW'({nib[HW-1:0], ras_lo});
    times[int'(F_RC)]  = TW'({nib[BW-1:HW], rc_lo});
    times[int'(F_RFC)] = TW'({rfc_hi, rfc_lo});
    times[int'(F_FAW)] = TW'({faw_hi, faw_lo});
    times[int'(F_RRD)] = TW'(t_rrd);
    times[int'(F_WTR)] = TW'(t_wtr);
    times[int'(F_RTP)] = TW'(t_rtp);
    cl_mask = MW'({m_hi, m_lo});
  end

  logic [15*BW-1:0] image;
  assign image = {m_lo, m_hi, t_aa, t_rcd, t_rrd, t_rp, nib, ras_lo, rc_lo,
                  rfc_lo, rfc_hi, t_wtr, t_rtp, faw_lo, BW'(faw_hi)};

  p_no_write_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(image));
  p_unmapped_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (int'(wr_addr) == 17 || int'(wr_addr) < 14 || int'(wr_addr) > 29))
      |=> $stable(image));
endmodule

// File: rtl/spd_ceil_div.sv
module spd_ceil_div #(
  parameter int NW = 17,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          busy,
  output logic          fin,
  output logic [NW-1:0] quo
);
  localparam int CW = $clog2(NW + 1);

  logic [NW-1:0] acc;
  logic [DW-1:0] rem, den_q;
  logic [CW-1:0] cnt;
  logic [DW:0]   trial, diff;
  logic          ge;

  always_comb begin
    trial = {rem, acc[NW-1]};
    ge    = trial >= {1'b0, den_q};
    diff  = trial - {1'b0, den_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0; rem <= '0; den_q <= '0; cnt <= '0; fin <= 1'b0;
    end else if (start) begin
      acc <= num; rem <= '0; den_q <= den; cnt <= CW'(NW); fin <= 1'b0;
    end else if (cnt != '0) begin
      acc <= {acc[NW-2:0], ge};
      rem <= ge ? diff[DW-1:0] : trial[DW-1:0];
      cnt <= cnt - 1'b1;
      fin <= (cnt == CW'(1));
    end else begin
      fin <= 1'b0;
    end
  end

  assign busy = (cnt != '0);
  assign quo  = acc;

  p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  p_rem_below_den_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && den_q != '0) |-> rem < den_q);
  p_fin_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin);
endmodule

// File: rtl/spd_cl_pick.sv
module spd_cl_pick #(
  parameter int MW   = 16,
  parameter int BASE = 4,
  parameter int NW   = 16,
  parameter int CLW  = 5
) (
  input  logic [MW-1:0]  mask,
  input  logic [NW-1:0]  need,
  output logic [CLW-1:0] cl,
  output logic           found
);
  always_comb begin
    cl    = '0;
    found = 1'b0;
    for (int i = MW - 1; i >= 0; i--) begin
      if (mask[i] && (NW'(i + BASE) >= need)) begin
        found = 1'b1;
        cl    = CLW'(i + BASE);
      end
    end
  end
endmodule

// File: rtl/spd_timing_decoder.sv
module spd_timing_decoder
  import spd_pkg::*;
#(
  parameter  int BW   = BYTE_W,
  parameter  int TW   = TIME_W,
  localparam int CL_W = $clog2(CL_BASE + MASK_W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [BW-1:0]   in_addr,
  input  logic [BW-1:0]   in_data,
  input  logic            go,
  input  logic [BW-1:0]   tck_units,
  output logic            done,
  output logic [CL_W-1:0] cl_sel,
  output logic            cl_err,
  output logic [TW-1:0]   cyc_aa,
  output logic [TW-1:0]   cyc_rcd,
  output logic [TW-1:0]   cyc_rp,
  output logic [TW-1:0]   cyc_ras,
  output logic [TW-1:0]   cyc_rc,
  output logic [TW-1:0]   cyc_rfc,
  output logic [TW-1:0]   cyc_faw,
  output logic [TW-1:0]   cyc_rrd,
  output logic [TW-1:0]   cyc_wtr,
  output logic [TW-1:0]   cyc_rtp
);
  localparam int NW = TW + 1;
  localparam int IW = $clog2(NF);

  typedef enum logic [1:0] {S_IDLE, S_DIV, S_PICK} state_e;

  state_e          state;
  logic [IW-1:0]   idx;
  logic [BW-1:0]   tck_q;
  logic            div_start, div_busy, div_fin, pick_found;
  logic [NW-1:0]   num, quo;
  logic [TW-1:0]   times [NF];
  logic [TW-1:0]   cyc_q [NF];
  logic [MASK_W-1:0] mask;
  logic [CL_W-1:0] pick_cl;

  assign in_ready = (state == S_IDLE);

  spd_byte_capture #(.BW(BW), .TW(TW), .MW(MASK_W)) cap_i (
    .clk, .rst_n, .wr_en(in_valid && in_ready), .wr_addr(in_addr),
    .wr_data(in_data), .times, .cl_mask(mask));

  // ceil(t/p) as floor((t + p - 1) / p)
  assign num = {1'b0, times[idx]} + NW'(tck_q) - NW'(1);

  spd_ceil_div #(.NW(NW), .DW(BW)) div_i (
    .clk, .rst_n, .start(div_start), .num, .den(tck_q),
    .busy(div_busy), .fin(div_fin), .quo);

  spd_cl_pick #(.MW(MASK_W), .BASE(CL_BASE), .NW(TW), .CLW(CL_W)) pick_i (
    .mask, .need(cyc_q[int'(F_AA)]), .cl(pick_cl), .found(pick_found));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; idx <= '0; tck_q <= '0; div_start <= 1'b0;
      done <= 1'b0; cl_sel <= '0; cl_err <= 1'b0;
      for (int k = 0; k < NF; k++) cyc_q[k] <= '0;
    end else begin
      done      <= 1'b0;
      div_start <= 1'b0;
      case (state)
        S_IDLE: if (go) begin
          tck_q <= tck_units; idx <= '0; div_start <= 1'b1; state <= S_DIV;
        end
        S_DIV: if (div_fin) begin
          cyc_q[idx] <= quo[TW] ? '1 : quo[TW-1:0];
          if (int'(idx) == NF - 1) state <= S_PICK;
          else begin
            idx <= idx + 1'b1; div_start <= 1'b1;
          end
        end
        S_PICK: begin
          cl_sel <= pick_cl; cl_err <= !pick_found; done <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cyc_aa  = cyc_q[int'(F_AA)];
  assign cyc_rcd = cyc_q[int'(F_RCD)];
  assign cyc_rp  = cyc_q[int'(F_RP)];
  assign cyc_ras = cyc_q[int'(F_RAS)];
  assign cyc_rc  = cyc_q[int'(F_RC)];
  assign cyc_rfc = cyc_q[int'(F_RFC)];
  assign cyc_faw = cyc_q[int'(F_FAW)];
  assign cyc_rrd = cyc_q[int'(F_RRD)];
  assign cyc_wtr = cyc_q[int'(F_WTR)];
  assign cyc_rtp = cyc_q[int'(F_RTP)];

  p_go_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (go && in_ready) |=> !in_ready);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_busy_div_r8: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy |-> !done);
  p_cl_covers_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cl_err) |-> TW'(cl_sel) >= cyc_aa);
  p_err_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cl_err) |-> cl_sel == '0);
  p_ceil_enough_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && tck_q != '0) |->
      32'(cyc_aa) * 32'(tck_q) >= 32'(times[int'(F_AA)]));
  p_ceil_tight_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && tck_q != '0 && cyc_aa != '0) |->
      (32'(cyc_aa) - 32'd1) * 32'(tck_q) < 32'(times[int'(F_AA)]));
endmodule

// File: tb/spd_timing_decoder_tb_top.sv
`timescale 1ns/1ps
module spd_timing_decoder_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic in_valid = 1'b0, in_ready, go = 1'b0, done, cl_err;
  logic [7:0] in_addr = '0, in_data = '0, tck_units = '0;
  logic [4:0] cl_sel;
  logic [15:0] c_aa, c_rcd, c_rp, c_ras, c_rc, c_rfc, c_faw, c_rrd, c_wtr, c_rtp;

  spd_timing_decoder dut_i (
    .clk, .rst_n, .in_valid, .in_ready, .in_addr, .in_data, .go, .tck_units,
    .done, .cl_sel, .cl_err, .cyc_aa(c_aa), .cyc_rcd(c_rcd), .cyc_rp(c_rp),
    .cyc_ras(c_ras), .cyc_rc(c_rc), .cyc_rfc(c_rfc), .cyc_faw(c_faw),
    .cyc_rrd(c_rrd), .cyc_wtr(c_wtr), .cyc_rtp(c_rtp));

  typedef struct packed {
    logic [9:0][15:0] cyc;
    logic [4:0]       cl;
    logic             err;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int checks = 0, errors = 0;
  logic [7:0] img [0:31];
  bit finished = 0, chk_next = 0;

  task automatic chk(string req, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic wr_byte(int a, int d);
    @(negedge clk);
    in_valid = 1'b1; in_addr = 8'(a); in_data = 8'(d);
    @(negedge clk);
    in_valid = 1'b0;
    if (a < 32) img[a] = 8'(d);
  endtask

  // driver: builds expectation from the requirement text and starts a run
  task automatic launch(int tck, string tag);
    exp_t e;
    int t[10];
    logic [15:0] m;
    t[0] = img[16]; t[1] = img[18]; t[2] = img[20];
    t[3] = {img[21][3:0], img[22]}; t[4] = {img[21][7:4], img[23]};
    t[5] = {img[25], img[24]}; t[6] = {img[28][3:0], img[29]};
    t[7] = img[19]; t[8] = img[26]; t[9] = img[27];
    for (int k = 0; k < 10; k++) e.cyc[k] = 16'((t[k] + tck - 1) / tck);
    m = {img[15], img[14]};
    e.err = 1'b1; e.cl = '0;
    for (int i = 0; i < 16; i++)
      if (e.err && m[i] && (i + 4) >= int'(e.cyc[0])) begin
        e.err = 1'b0; e.cl = 5'(i + 4);
      end
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); go = 1'b1; tck_units = 8'(tck);
    @(negedge clk); go = 1'b0;
    chk("R1", "in_ready after go", int'(in_ready), 0);
    // offer a byte while busy: must be held off (R1)
    in_valid = 1'b1; in_addr = 8'd16; in_data = 8'hEE;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    while (!in_ready) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (chk_next) begin
      chk("R8", "done single pulse", int'(done), 0);
      chk_next = 0;
    end
    if (rst_n && done) begin
      if (exp_q.size() == 0) chk("R8", "unexpected done", 1, 0);
      else begin
        exp_t e; string tg;
        e = exp_q.pop_front(); tg = tag_q.pop_front();
        chk(tg, "cyc_aa",  int'(c_aa),  int'(e.cyc[0]));
        chk(tg, "cyc_rcd", int'(c_rcd), int'(e.cyc[1]));
        chk(tg, "cyc_rp",  int'(c_rp),  int'(e.cyc[2]));
        chk(tg, "cyc_ras", int'(c_ras), int'(e.cyc[3]));
        chk(tg, "cyc_rc",  int'(c_rc),  int'(e.cyc[4]));
        chk(tg, "cyc_rfc", int'(c_rfc), int'(e.cyc[5]));
        chk(tg, "cyc_faw", int'(c_faw), int'(e.cyc[6]));
        chk(tg, "cyc_rrd", int'(c_rrd), int'(e.cyc[7]));
        chk(tg, "cyc_wtr", int'(c_wtr), int'(e.cyc[8]));
        chk(tg, "cyc_rtp", int'(c_rtp), int'(e.cyc[9]));
        chk(e.err ? "R7" : "R6", "cl_sel", int'(cl_sel), int'(e.cl));
        chk(e.err ? "R7" : "R6", "cl_err", int'(cl_err), int'(e.err));
        chk_next = 1;
      end
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) img[i] = '0;
    repeat (3) @(negedge clk);
    chk("R10", "in_ready", int'(in_ready), 1);
    chk("R10", "done", int'(done), 0);
    chk("R10", "cl_err", int'(cl_err), 0);
    chk("R10", "cl_sel", int'(cl_sel), 0);
    chk("R10", "cyc_rfc", int'(c_rfc), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "in_ready after release", int'(in_ready), 1);

    // A: realistic table at 1.25 ns (R2): aa 11, ras 28, rc 39, rfc 88, faw 24
    wr_byte(14, 8'hBC); wr_byte(15, 8'h00); wr_byte(16, 8'h69);
    wr_byte(18, 8'h69); wr_byte(19, 8'h30); wr_byte(20, 8'h69);
    wr_byte(21, 8'h11); wr_byte(22, 8'h18); wr_byte(23, 8'h86);
    wr_byte(24, 8'h70); wr_byte(25, 8'h03); wr_byte(26, 8'h3C);
    wr_byte(27, 8'h3C); wr_byte(28, 8'h00); wr_byte(29, 8'hF0);
    launch(10, "R2");
    // B: same bytes, new period (R4, R11): aa 9 -> CL 9
    launch(12, "R4 R11");
    // C: exact multiple at 1.875 ns (R5): 105/15 = 7
    launch(15, "R5");
    // D: unmapped addresses written (R9)
    wr_byte(17, 8'hFF); wr_byte(12, 8'h01); wr_byte(30, 8'hAA); wr_byte(13, 8'h55);
    launch(10, "R9");
    // D2: only high-byte mask bit 10 -> CL 14 at 1.0 ns (R6)
    wr_byte(14, 8'h00); wr_byte(15, 8'h04);
    launch(8, "R6");
    // E: only CL 6 supported, need 11 (R7)
    wr_byte(14, 8'h04); wr_byte(15, 8'h00);
    launch(10, "R7");
    // F: nibble-rich split fields, upper nibble of 28 set (R3)
    wr_byte(21, 8'hA5); wr_byte(22, 8'h3C); wr_byte(23, 8'h7E);
    wr_byte(24, 8'h34); wr_byte(25, 8'h12); wr_byte(28, 8'hEB);
    wr_byte(29, 8'h99); wr_byte(14, 8'hFF); wr_byte(15, 8'hFF);
    launch(7, "R3");

    repeat (4) @(negedge clk);
    chk("R8", "all runs completed", exp_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule